// File: doc/BRIEF.md
# Round-Robin SIMT Unit Issue Scheduler

This block sits at the issue front end of one compute unit that holds several SIMT execution units. Each execution unit keeps a small set of wavefront slots. For every slot the surrounding logic presents a valid flag, a ready flag and a wavefront ID. On each clock the scheduler gives the turn to exactly one execution unit, in a fixed rotation. If that unit is free and holds a slot that is both valid and ready, the scheduler issues one wavefront instruction from that slot. The issue output then carries the unit index, the slot index and the wavefront ID.

An issued wavefront occupies its unit for a fixed number of cycles while the work-items sweep across the narrower lane datapath. With the default sizes this is 64 work-items on 16 lanes, which takes 4 cycles. Because the rotation covers four units, each unit is revisited exactly when it frees up. The staggered units therefore take in one wavefront per cycle overall. Each unit keeps a rotating slot pointer so that its slots are served fairly. The scheduler also keeps a per-unit occupancy counter and shows it on a busy output.

Top module: `rr_issue_sched`

## Requirements
- R1: While `rst` is high at a rising edge, `issue_vld` and every bit of `unit_busy` are 0 after that edge. The first rising edge with `rst` low gives the turn to unit 0.
- R2: The turn advances by one unit at every rising edge, wrapping from UNITS-1 to 0, whether or not an issue takes place. An issue produced at the n-th edge after reset (n counted from 0) always names unit n mod UNITS.
- R3: A slot can be issued only if its bits of `slot_valid` and `slot_ready` are both 1 at the sampling edge. Slot (u,s) uses bit u*SLOTS+s of each flag vector. A ready flag on a slot whose valid flag is low has no effect.
- R4: After a unit issues at edge e, it cannot issue again at edges e+1 through e+OCC_CYCLES-1. It is eligible again from edge e+OCC_CYCLES.
- R5: Within the unit whose turn it is, the issued slot is the first eligible slot at or after that unit's slot pointer, searching upward and wrapping. After an issue, the pointer moves to the issued slot plus one, and from the last slot back to slot 0. Each unit's pointer starts at 0 after reset.
- R6: If the unit whose turn it is is busy or has no eligible slot, `issue_vld` is 0 after that edge. Neither slot pointers nor occupancy of any other kind change beyond normal countdown.
- R7: The issue outputs are registered. They appear after the edge that sampled the inputs. `issue_wid` equals bits [(u*SLOTS+s)*WID_W +: WID_W] of `slot_wid` as sampled at that edge, for the issued unit u and slot s.
- R8: `unit_busy[u]` is 1 after edges e through e+OCC_CYCLES-2 following an issue to unit u at edge e. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | UNITS*SLOTS | Slot holds a resident wavefront, bit u*SLOTS+s |
| slot_ready | input | UNITS*SLOTS | Slot's next instruction may issue, bit u*SLOTS+s |
| slot_wid | input | UNITS*SLOTS*WID_W | Wavefront ID per slot, field u*SLOTS+s |
| issue_vld | output | 1 | An instruction was issued this cycle |
| issue_unit | output | UIDX_W | Index of the unit issued to |
| issue_slot | output | SIDX_W | Index of the slot issued from |
| issue_wid | output | WID_W | Wavefront ID of the issued slot |
| unit_busy | output | UNITS | Per-unit occupancy still in progress |

## Verification
The bench builds the scheduler with four units, six slots per unit and an occupancy of six cycles. Occupancy that outlasts the four-cycle rotation makes a unit turn down its own turn while busy, so the blocking and busy-flag rules are exercised rather than always hidden by the rhythm. Six slots keep the wrap of the slot pointer from the last slot to slot 0 frequent under random valid and ready patterns. Directed phases cover the first issue after reset, ready-without-valid stimulus, and a single eligible slot parked in the last position.

// File: rtl/rr_issue_pkg.sv
package rr_issue_pkg;

    localparam int unsigned DEF_UNITS   = 4;
    localparam int unsigned DEF_SLOTS   = 10;
    localparam int unsigned DEF_OCC     = 4;
    localparam int unsigned DEF_WID_W   = 6;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int wrap_add(input int a, input int b, input int lim);
        int s;
        s = a + b;
        return (s >= lim) ? s - lim : s;
    endfunction

endpackage

// File: rtl/rr_slot_pick.sv
module rr_slot_pick
    import rr_issue_pkg::*;
#(
    parameter int unsigned SLOTS  = DEF_SLOTS,
    parameter int unsigned SIDX_W = idx_width(SLOTS)
) (
    input  logic [SLOTS-1:0]  req,
    input  logic [SIDX_W-1:0] ptr,
    output logic              found,
    output logic [SIDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < int'(SLOTS); k++) begin
            if (!found && req[wrap_add(int'(ptr), k, int'(SLOTS))]) begin
                found = 1'b1;
                idx   = SIDX_W'(wrap_add(int'(ptr), k, int'(SLOTS)));
            end
        end
    end

endmodule

// File: rtl/rr_unit_state.sv
module rr_unit_state
    import rr_issue_pkg::*;
#(
    parameter int unsigned SLOTS      = DEF_SLOTS,
    parameter int unsigned OCC_CYCLES = DEF_OCC,
    parameter int unsigned SIDX_W     = idx_width(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOTS-1:0]  req,
    input  logic              grant,
    output logic              elig,
    output logic [SIDX_W-1:0] pick,
    output logic              busy
);

    localparam int unsigned CNT_W    = idx_width(OCC_CYCLES);
    localparam int unsigned OCC_LOAD = (OCC_CYCLES > 0) ? OCC_CYCLES - 1 : 0;

    logic [SIDX_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              found;

    rr_slot_pick #(
        .SLOTS  (SLOTS),
        .SIDX_W (SIDX_W)
    ) u_pick (
        .req   (req),
        .ptr   (ptr_q),
        .found (found),
        .idx   (pick)
    );

    assign busy = (cnt_q != '0);
    assign elig = found && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (grant) begin
            ptr_q <= (pick == SIDX_W'(SLOTS - 1)) ? '0 : pick + 1'b1;
            cnt_q <= CNT_W'(OCC_LOAD);
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/rr_issue_sched.sv
module rr_issue_sched
    import rr_issue_pkg::*;
#(
    parameter int unsigned UNITS      = DEF_UNITS,
    parameter int unsigned SLOTS      = DEF_SLOTS,
    parameter int unsigned OCC_CYCLES = DEF_OCC,
    parameter int unsigned WID_W      = DEF_WID_W,
    parameter int unsigned UIDX_W     = idx_width(UNITS),
    parameter int unsigned SIDX_W     = idx_width(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [UNITS*SLOTS-1:0]       slot_valid,
    input  logic [UNITS*SLOTS-1:0]       slot_ready,
    input  logic [UNITS*SLOTS*WID_W-1:0] slot_wid,
    output logic                         issue_vld,
    output logic [UIDX_W-1:0]            issue_unit,
    output logic [SIDX_W-1:0]            issue_slot,
    output logic [WID_W-1:0]             issue_wid,
    output logic [UNITS-1:0]             unit_busy
);

    typedef struct packed {
        logic              vld;
        logic [UIDX_W-1:0] unit;
        logic [SIDX_W-1:0] slot;
        logic [WID_W-1:0]  wid;
    } issue_t;

    logic [UIDX_W-1:0] turn_q;
    logic [UNITS-1:0]  elig;
    logic [UNITS-1:0]  grant;
    logic [SIDX_W-1:0] pick_arr [UNITS];
    issue_t            sel;
    issue_t            out_q;

    for (genvar u = 0; u < int'(UNITS); u++) begin : g_unit
        assign grant[u] = !rst && (turn_q == UIDX_W'(u)) && elig[u];

        rr_unit_state #(
            .SLOTS      (SLOTS),
            .OCC_CYCLES (OCC_CYCLES),
            .SIDX_W     (SIDX_W)
        ) u_state (
            .clk   (clk),
            .rst   (rst),
            .req   (slot_valid[u*SLOTS +: SLOTS] & slot_ready[u*SLOTS +: SLOTS]),
            .grant (grant[u]),
            .elig  (elig[u]),
            .pick  (pick_arr[u]),
            .busy  (unit_busy[u])
        );
    end

    always_comb begin
        int base;
        sel.vld  = |grant;
        sel.unit = turn_q;
        sel.slot = pick_arr[turn_q];
        base     = int'(turn_q) * int'(SLOTS) + int'(sel.slot);
        sel.wid  = slot_wid[base*int'(WID_W) +: WID_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            turn_q <= '0;
            out_q  <= '0;
        end else begin
            turn_q <= (turn_q == UIDX_W'(UNITS - 1)) ? '0 : turn_q + 1'b1;
            out_q  <= sel;
        end
    end

    assign issue_vld  = out_q.vld;
    assign issue_unit = out_q.unit;
    assign issue_slot = out_q.slot;
    assign issue_wid  = out_q.wid;

endmodule

// File: rtl/rr_issue_sched_chk.sv
module rr_issue_sched_chk #(
    parameter int unsigned UNITS      = 4,
    parameter int unsigned SLOTS      = 10,
    parameter int unsigned OCC_CYCLES = 4,
    parameter int unsigned WID_W      = 6,
    parameter int unsigned UIDX_W     = 2,
    parameter int unsigned SIDX_W     = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [UNITS*SLOTS-1:0]       slot_valid,
    input logic [UNITS*SLOTS-1:0]       slot_ready,
    input logic [UNITS*SLOTS*WID_W-1:0] slot_wid,
    input logic                         issue_vld,
    input logic [UIDX_W-1:0]            issue_unit,
    input logic [SIDX_W-1:0]            issue_slot,
    input logic [WID_W-1:0]             issue_wid,
    input logic [UNITS-1:0]             unit_busy
);

    logic [UIDX_W-1:0]            ph_q;
    logic [UNITS*SLOTS-1:0]       prev_elig;
    logic [UNITS*SLOTS*WID_W-1:0] prev_wid;
    logic [UNITS-1:0]             prev_busy;
    logic [UIDX_W-1:0]            exp_unit;
    logic [WID_W-1:0]             exp_wid;
    logic                         exp_slot_ok;
    int                           flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= '0;
            prev_elig <= '0;
            prev_wid  <= '0;
            prev_busy <= '0;
        end else begin
            ph_q      <= (ph_q == UIDX_W'(UNITS - 1)) ? '0 : ph_q + 1'b1;
            prev_elig <= slot_valid & slot_ready;
            prev_wid  <= slot_wid;
            prev_busy <= unit_busy;
        end
    end

    always_comb begin
        exp_unit    = (ph_q == '0) ? UIDX_W'(UNITS - 1) : ph_q - 1'b1;
        flat        = int'(issue_unit) * int'(SLOTS) + int'(issue_slot);
        exp_slot_ok = 1'b0;
        exp_wid     = '0;
        if (flat < int'(UNITS * SLOTS)) begin
            exp_slot_ok = prev_elig[flat];
            exp_wid     = prev_wid[flat*int'(WID_W) +: WID_W];
        end
    end

    a_r2_rotation: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> issue_unit == exp_unit);

    a_r3_slot_eligible: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> exp_slot_ok);

    a_r4_not_busy: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> !prev_busy[issue_unit]);

    a_r5_slot_range: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> int'(issue_slot) < int'(SLOTS));

    a_r7_wid_match: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> issue_wid == exp_wid);

    a_r8_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && OCC_CYCLES > 1) |-> unit_busy[issue_unit]);

endmodule

bind rr_issue_sched rr_issue_sched_chk #(
    .UNITS      (UNITS),
    .SLOTS      (SLOTS),
    .OCC_CYCLES (OCC_CYCLES),
    .WID_W      (WID_W),
    .UIDX_W     (UIDX_W),
    .SIDX_W     (SIDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (slot_valid),
    .slot_ready (slot_ready),
    .slot_wid   (slot_wid),
    .issue_vld  (issue_vld),
    .issue_unit (issue_unit),
    .issue_slot (issue_slot),
    .issue_wid  (issue_wid),
    .unit_busy  (unit_busy)
);

// File: tb/rr_issue_sched_tb.sv
module rr_issue_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int U   = 4;
    localparam int S   = 6;
    localparam int OCC = 6;
    localparam int W   = 6;
    localparam int UW  = 2;
    localparam int SW  = 3;
    localparam int N   = U * S;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    vld = '0;
    logic [N-1:0]    rdy = '0;
    logic [N*W-1:0]  wid = '0;
    logic            issue_vld;
    logic [UW-1:0]   issue_unit;
    logic [SW-1:0]   issue_slot;
    logic [W-1:0]    issue_wid;
    logic [U-1:0]    unit_busy;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int m_turn;
    int m_ptr [U];
    int m_cnt [U];
    bit e_vld;
    int e_unit, e_slot, e_wid;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_issue_sched #(
        .UNITS(U), .SLOTS(S), .OCC_CYCLES(OCC), .WID_W(W)
    ) u_dut (
        .clk(clk), .rst(rst),
        .slot_valid(vld), .slot_ready(rdy), .slot_wid(wid),
        .issue_vld(issue_vld), .issue_unit(issue_unit),
        .issue_slot(issue_slot), .issue_wid(issue_wid),
        .unit_busy(unit_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_turn = 0;
        for (int u = 0; u < U; u++) begin
            m_ptr[u] = 0;
            m_cnt[u] = 0;
        end
    endtask

    // Expected result of the next edge from the requirements, then post-edge state.
    task automatic model_step();
        int u;
        u     = m_turn;
        e_vld = 0;
        e_unit = u;
        e_slot = 0;
        e_wid  = 0;
        if (m_cnt[u] == 0) begin
            for (int k = 0; k < S; k++) begin
                int s;
                s = (m_ptr[u] + k) % S;
                if (!e_vld && vld[u*S+s] && rdy[u*S+s]) begin
                    e_vld  = 1;
                    e_slot = s;
                    e_wid  = int'(wid[(u*S+s)*W +: W]);
                end
            end
        end
        for (int x = 0; x < U; x++)
            if (m_cnt[x] > 0) m_cnt[x]--;
        if (e_vld) begin
            m_cnt[u] = OCC - 1;
            m_ptr[u] = (e_slot + 1) % S;
        end
        m_turn = (m_turn + 1) % U;
    endtask

    task automatic compare();
        chk(issue_vld == e_vld, "R2/R6 issue_vld", int'(issue_vld), int'(e_vld));
        if (e_vld && issue_vld) begin
            chk(int'(issue_unit) == e_unit, "R2 issue_unit", int'(issue_unit), e_unit);
            chk(int'(issue_slot) == e_slot, "R5 issue_slot", int'(issue_slot), e_slot);
            chk(int'(issue_wid) == e_wid, "R7 issue_wid", int'(issue_wid), e_wid);
        end
        for (int x = 0; x < U; x++)
            chk(unit_busy[x] == (m_cnt[x] != 0), "R4/R8 unit_busy",
                int'(unit_busy[x]), int'(m_cnt[x] != 0));
    endtask

    // Inputs are already set (driven at negedge); run one edge and check.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic rand_ids();
        for (int i = 0; i < N; i++) wid[i*W +: W] = W'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        rand_ids();
        vld = '1;
        rdy = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(issue_vld == 1'b0, "R1 issue_vld in reset", int'(issue_vld), 0);
        chk(unit_busy == '0, "R1 unit_busy in reset", int'(unit_busy), 0);
        rst = 1'b0;

        // R1: first edge after reset issues unit 0 slot 0
        step();
        chk(issue_vld && issue_unit == 0 && issue_slot == 0, "R1 first issue unit0 slot0",
            int'(issue_unit) * 16 + int'(issue_slot), 0);
        for (int c = 0; c < 40; c++) step();

        // R3: ready without valid has no effect
        vld = '0;
        rdy = '1;
        for (int c = 0; c < 12; c++) begin
            step();
            chk(issue_vld == 1'b0, "R3 ready without valid", int'(issue_vld), 0);
        end

        // R5/R6: only the last slot of unit 2 eligible
        vld = '0;
        rdy = '0;
        vld[2*S + S-1] = 1'b1;
        rdy[2*S + S-1] = 1'b1;
        for (int c = 0; c < 24; c++) begin
            step();
            if (issue_vld)
                chk(issue_unit == 2 && int'(issue_slot) == S-1, "R5 last-slot issue",
                    int'(issue_unit) * 16 + int'(issue_slot), 2 * 16 + S - 1);
        end

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                vld[i] = ($urandom % 10) < 6;
                rdy[i] = ($urandom % 2) == 0;
            end
            if (($urandom % 4) == 0) rand_ids();
            step();
        end

        // Reset in mid-run: R1 again
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(issue_vld == 1'b0, "R1 issue_vld after reset", int'(issue_vld), 0);
        chk(unit_busy == '0, "R1 unit_busy after reset", int'(unit_busy), 0);
        model_reset();
        rst = 1'b0;
        vld = '1;
        rdy = '1;
        for (int c = 0; c < 20; c++) step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule